// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits beside a processor core and decides which of four interrupt sources may interrupt the code that is running now. Requests are caught in a pending register. Each source is mapped onto one of four priority levels. A pending source is accepted only if its level is strictly above every level already in service, so handlers nest: a higher-level request can interrupt a lower-level handler, and a request at the same or a lower level waits.

A global enable gate controls all acceptance. An enable strobe opens it and a disable strobe closes it, one strobe for each of the two instructions. A 2-bit configuration field selects which source is ranked lowest. The ranking then rises by source index and wraps around. This field is locked while any level is in service. Each acceptance raises a one-cycle acknowledge that carries the source index. A return strobe retires the highest level in service, which lets lower levels through again.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `ack` is 0, no request is pending, no level is in service, the global gate is closed, and the lowest-ranked source is 0.
- R2: A request bit high at an edge marks that source pending. It stays pending until it is acknowledged. If the same source is acknowledged and requested in the same cycle, it stays pending.
- R3: With configuration value k, source i has level (i - k) mod 4, where level 3 is the highest. `ack_id` carries the source index i. When several sources are pending and eligible, the one with the highest level is accepted.
- R4: A pending source is eligible only if no level is in service or its level is strictly greater than the highest level in service. A request at the same or a lower level stays pending.
- R5: If a source becomes pending at edge n and is eligible, `ack` is high for exactly the cycle after edge n+1. Each acceptance gives one such pulse, and it also marks that level as in service.
- R6: `ei` opens the global gate and `di` closes it. If both are high, `di` wins. While the gate is closed nothing is accepted and requests stay pending.
- R7: A `cfg_wr` strobe loads `cfg_lowest` only in a cycle where no level is in service and no acceptance is being made. In any other cycle the strobe is ignored.
- R8: `reti` clears the highest level in service, and no acceptance is made in a cycle where `reti` is high. A `reti` while nothing is in service has no effect.
- R9: While level 3 is in service, no source is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 4 | Request strobes, one for each source |
| ei | input | 1 | Open the global gate |
| di | input | 1 | Close the global gate (wins over `ei`) |
| cfg_wr | input | 1 | Write strobe for the ranking field |
| cfg_lowest | input | 2 | Index of the source ranked lowest |
| reti | input | 1 | Return from the current handler |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_id | output | 2 | Index of the accepted source |

## Verification
The hardest situations to reach are the collisions: a configuration write in the same cycle as an acceptance, and a return in the same cycle as a pending eligible request. Both need a request timed to latch exactly one edge before the strobe arrives. Directed phases create each collision on purpose. They also build a chain of three nested levels, so a same-level request is refused and then accepted after a return. A long random phase mixes rare gate and configuration strobes with frequent returns, so that locked and unlocked configuration writes both occur many times.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  // Level to source mapping: the lowest-ranked source plus the level, wrapped.
  function automatic int unsigned lvl_to_src(int unsigned lvl, int unsigned lowest,
                                             int unsigned nsrc);
    return (lvl + lowest) % nsrc;
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_SRC = 4,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               clr_vld,
  input  logic [ID_W-1:0]    clr_id,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] clr_mask;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    assign clr_mask[g] = clr_vld && (clr_id == g[ID_W-1:0]);

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && !clr_mask[g]) |=> pend[g]); // R2
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | req;
  end
endmodule

// File: rtl/irq_rank_arb.sv
module irq_rank_arb #(
  parameter int NUM_SRC = 4,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [ID_W-1:0]    lowest,
  input  logic               allow,
  input  logic               top_vld,
  input  logic [ID_W-1:0]    top_lvl,
  output logic               win_vld,
  output logic [ID_W-1:0]    win_src,
  output logic [ID_W-1:0]    win_lvl
);
  import irq_nest_pkg::*;

  int unsigned src_ix [NUM_SRC];

  for (genvar l = 0; l < NUM_SRC; l++) begin : g_map
    assign src_ix[l] = lvl_to_src(l, int'(lowest), NUM_SRC);
  end

  // Ascending scan, so the highest eligible level is the one that remains.
  always_comb begin
    win_vld = 1'b0;
    win_src = '0;
    win_lvl = '0;
    for (int l = 0; l < NUM_SRC; l++) begin
      if (allow && pend[src_ix[l]] && (!top_vld || l > int'(top_lvl))) begin
        win_vld = 1'b1;
        win_src = src_ix[l][ID_W-1:0];
        win_lvl = l[ID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int NUM_SRC = 4,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_lvl,
  input  logic            pop,
  output logic            top_vld,
  output logic [ID_W-1:0] top_lvl,
  output logic            busy
);
  logic [NUM_SRC-1:0] svc_q;
  logic [NUM_SRC-1:0] svc_d;

  always_comb begin
    top_vld = 1'b0;
    top_lvl = '0;
    for (int l = 0; l < NUM_SRC; l++) begin
      if (svc_q[l]) begin
        top_vld = 1'b1;
        top_lvl = l[ID_W-1:0];
      end
    end
  end

  assign busy = |svc_q;

  always_comb begin
    svc_d = svc_q;
    if (pop && top_vld) svc_d[top_lvl] = 1'b0;
    if (push)           svc_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) svc_q <= '0;
    else     svc_q <= svc_d;
  end

  AST_PUSH_ABOVE_TOP: assert property (@(posedge clk) disable iff (rst)
    push |-> (!top_vld || push_lvl > top_lvl)); // R4

  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (pop && top_vld && !push) |=> (!top_vld || top_lvl < $past(top_lvl))); // R8
endmodule

// File: rtl/irq_rank_cfg.sv
module irq_rank_cfg #(
  parameter int NUM_SRC = 4,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [ID_W-1:0] wr_data,
  input  logic            busy,
  input  logic            hold,
  output logic [ID_W-1:0] lowest
);
  always_ff @(posedge clk) begin
    if (rst)                       lowest <= '0;
    else if (wr && !busy && !hold) lowest <= wr_data;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(lowest)); // R7
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NUM_SRC = 4,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               ei,
  input  logic               di,
  input  logic               cfg_wr,
  input  logic [ID_W-1:0]    cfg_lowest,
  input  logic               reti,
  output logic               ack,
  output logic [ID_W-1:0]    ack_id
);
  logic [NUM_SRC-1:0] pend;
  logic [ID_W-1:0]    lowest;
  logic               gate_q;
  logic               allow;
  logic               top_vld;
  logic [ID_W-1:0]    top_lvl;
  logic               busy;
  logic               win_vld;
  logic [ID_W-1:0]    win_src;
  logic [ID_W-1:0]    win_lvl;

  always_ff @(posedge clk) begin
    if (rst)     gate_q <= 1'b0;
    else if (di) gate_q <= 1'b0;
    else if (ei) gate_q <= 1'b1;
  end

  assign allow = gate_q && !reti;

  irq_pend_latch #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .req(irq_req),
    .clr_vld(win_vld), .clr_id(win_src), .pend(pend)
  );

  irq_rank_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_data(cfg_lowest),
    .busy(busy), .hold(win_vld), .lowest(lowest)
  );

  irq_rank_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend(pend), .lowest(lowest), .allow(allow),
    .top_vld(top_vld), .top_lvl(top_lvl),
    .win_vld(win_vld), .win_src(win_src), .win_lvl(win_lvl)
  );

  irq_svc_stack #(.NUM_SRC(NUM_SRC)) u_stack (
    .clk(clk), .rst(rst), .push(win_vld), .push_lvl(win_lvl), .pop(reti),
    .top_vld(top_vld), .top_lvl(top_lvl), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      ack_id <= '0;
    end else begin
      ack    <= win_vld;
      ack_id <= win_src;
    end
  end

  AST_ACK_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(gate_q)); // R6

  AST_NO_ACK_AFTER_RETI: assert property (@(posedge clk) disable iff (rst)
    $past(reti) |-> !ack); // R8

  AST_TOP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    (top_vld && top_lvl == ID_W'(NUM_SRC - 1) && !reti) |=> !ack); // R9
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       ei = 1'b0, di = 1'b0, cfg_wr = 1'b0, reti = 1'b0;
  logic [1:0] cfg_d = '0;
  logic       ack;
  logic [1:0] ack_id;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  int m_pend[N];
  int m_svc[N];
  int m_cfg, m_en, m_ack, m_id;
  int t_top, t_acc, t_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst(rst), .irq_req(req), .ei(ei), .di(di),
    .cfg_wr(cfg_wr), .cfg_lowest(cfg_d), .reti(reti),
    .ack(ack), .ack_id(ack_id)
  );

  // Behavioural reference: updated at each rising edge from the inputs held then.
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_svc[i] = 0; end
      m_cfg = 0; m_en = 0; m_ack = 0; m_id = 0;
    end else begin
      t_top = -1;
      for (int l = 0; l < N; l++) if (m_svc[l] != 0) t_top = l;
      t_acc = -1; t_src = 0;
      if (m_en != 0 && !reti)
        for (int l = N - 1; l > t_top; l--)
          if (t_acc < 0 && m_pend[(l + m_cfg) % N] != 0) begin
            t_acc = l; t_src = (l + m_cfg) % N;
          end
      if (t_acc >= 0) m_pend[t_src] = 0;
      for (int i = 0; i < N; i++) if (req[i]) m_pend[i] = 1;
      if (reti && t_top >= 0) m_svc[t_top] = 0;
      if (t_acc >= 0) m_svc[t_acc] = 1;
      if (cfg_wr && t_top < 0 && t_acc < 0) m_cfg = int'(cfg_d);
      if (di) m_en = 0; else if (ei) m_en = 1;
      if (t_acc >= 0) begin m_ack = 1; m_id = t_src; end
      else m_ack = 0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (ack !== m_ack[0] || (m_ack != 0 && ack_id !== m_id[1:0])) begin
        errors++;
        $display("FAIL %s: ack=%0b ack_id=%0d expected ack=%0d ack_id=%0d",
                 tag, ack, ack_id, m_ack, m_id);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(logic [3:0] v);
    req = v; tick(1); req = '0;
  endtask

  task automatic do_reti(int gap);
    reti = 1'b1; tick(1); reti = 1'b0; tick(gap);
  endtask

  task automatic do_ei();
    ei = 1'b1; tick(1); ei = 1'b0;
  endtask

  initial begin
    tick(1);
    // R1: reset state, then idle
    tag = "R1"; rst = 1'b1; tick(3); rst = 1'b0; tick(2);

    // R6: gate closed after reset, request waits; EI lets it in
    tag = "R6"; pulse_req(4'b0001); tick(4); do_ei(); tick(3);
    do_reti(2);
    di = 1'b1; tick(1); di = 1'b0;
    pulse_req(4'b1111); tick(3);
    ei = 1'b1; di = 1'b1; tick(1); ei = 1'b0; di = 1'b0; tick(3);

    // R3: all four pending, highest level first; R9: top level blocks all
    tag = "R3"; do_ei(); tick(2);
    tag = "R9"; tick(4); pulse_req(4'b0111); tick(3);
    tag = "R3"; do_reti(2); do_reti(2); do_reti(2); do_reti(2); do_reti(2);

    // R4: nesting upward, same or lower level held
    tag = "R4"; pulse_req(4'b0001); tick(3); pulse_req(4'b0010); tick(3);
    pulse_req(4'b0001); tick(2); pulse_req(4'b0010); tick(3);
    do_reti(3); do_reti(3); do_reti(3); do_reti(3);

    // R5: back-to-back preemption, one pulse per acceptance
    tag = "R5"; pulse_req(4'b0001); pulse_req(4'b0100); pulse_req(4'b1000); tick(3);
    do_reti(1); do_reti(1); do_reti(1); tick(2);

    // R7: locked while busy, ignored on an acceptance cycle, loaded when idle
    tag = "R7"; pulse_req(4'b0001); tick(2);
    cfg_wr = 1'b1; cfg_d = 2'd2; tick(1); cfg_wr = 1'b0;
    do_reti(2); pulse_req(4'b1111); tick(4); do_reti(2); do_reti(2); do_reti(2); do_reti(2);
    req = 4'b0001; tick(1); req = '0; cfg_wr = 1'b1; cfg_d = 2'd1; tick(1); cfg_wr = 1'b0;
    tick(2); do_reti(2);
    cfg_wr = 1'b1; cfg_d = 2'd2; tick(1); cfg_wr = 1'b0; tick(1);
    pulse_req(4'b1111); tick(3); do_reti(2); do_reti(2); do_reti(2); do_reti(2);
    pulse_req(4'b0011); tick(3); do_reti(2); do_reti(2);

    // R8: return with nothing in service; return holds off acceptance
    tag = "R8"; do_reti(2);
    req = 4'b0100; tick(1); req = '0; reti = 1'b1; tick(2); reti = 1'b0; tick(3);
    do_reti(2);

    // R2: request held across a long closed-gate window, re-request on ack
    tag = "R2"; di = 1'b1; tick(1); di = 1'b0;
    pulse_req(4'b0010); tick(10); do_ei(); req = 4'b0010; tick(1); req = '0;
    tick(3); do_reti(2); do_reti(2);

    // Mixed random traffic
    tag = "RND";
    for (int k = 0; k < 4000; k++) begin
      req    = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0000;
      reti   = (($urandom % 5) == 0);
      ei     = (($urandom % 20) == 0);
      di     = (($urandom % 40) == 0);
      cfg_wr = (($urandom % 15) == 0);
      cfg_d  = 2'($urandom);
      tick(1);
    end
    req = '0; reti = 1'b0; ei = 1'b0; di = 1'b0; cfg_wr = 1'b0;
    tick(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule